// File: doc/BRIEF.md
# Letterboxed XGA Video Timing Generator

This block produces the raster timing for a 1024x768 display running from a pixel clock of roughly 65 MHz, which gives about 60 frames per second. Each line takes 1344 clocks, 1024 of them visible. Each frame takes 806 lines, 768 of them visible. The picture source supplies only 720 lines. The generator centres that picture vertically and shows black on the 24 visible lines above it and the 24 below it.

For every image pixel the block raises a one-cycle read strobe that carries the pixel's column and image row. It asks for nothing on the black bands or in blanking. The source returns one RGB565 word in the cycle after the strobe. The block widens that word to 8 bits per channel and presents it on the colour outputs. The display data-enable and both active-low syncs are delayed to line up with the colour. Outside the visible area the colour outputs are forced to zero.

All horizontal and vertical segment lengths, the band offset and the image height are parameters. A small configuration can therefore be swept completely in simulation.

Top module: `letterbox_xga_timing`

## Requirements
- R1: The line is H_ACTIVE+H_FP+H_SYNC+H_BP clocks long. Counting from line position 0, `hsync_n` is low for exactly H_SYNC clocks, starting at position H_ACTIVE+H_FP (active low).
- R2: The frame is V_ACTIVE+V_FP+V_SYNC+V_BP lines. `vsync_n` is low for exactly the lines V_ACTIVE+V_FP to V_ACTIVE+V_FP+V_SYNC-1 (active low).
- R3: `disp_de` is high exactly when the line position is below H_ACTIVE and the line number is below V_ACTIVE. It is never high while either sync is low.
- R4: `pix_req` is high only for positions below H_ACTIVE on lines IMG_TOP to IMG_TOP+IMG_LINES-1. When it is high, `req_col` is the line position and `req_row` is the line number minus IMG_TOP.
- R5: On visible lines outside the image band, `disp_de` is high and the colour outputs are zero.
- R6: While `disp_de` is low, `red`, `green` and `blue` are all zero.
- R7: An input word has red in bits 15:11, green in bits 10:5 and blue in bits 4:0. It is widened by appending the top bits of each field below it: red {r5,r5[4:2]}, green {g6,g6[5:4]}, blue {b5,b5[4:2]}.
- R8: The source drives `pix_rgb565` during the cycle after `pix_req`. That pixel appears on the colour outputs, with its `disp_de` and syncs, two cycles after `pix_req`.
- R9: While `rst_n` is low, both syncs are high, and `disp_de`, `pix_req` and all colour outputs are low. After release, the raster starts at line 0, position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_rgb565 | input | 16 | Pixel word from the source, one cycle after the request |
| pix_req | output | 1 | Read strobe for one image pixel |
| req_col | output | $clog2(H_ACTIVE) | Column of the requested pixel |
| req_row | output | $clog2(IMG_LINES) | Image row of the requested pixel |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| disp_de | output | 1 | Display data enable |
| red | output | 8 | Red channel |
| green | output | 8 | Green channel |
| blue | output | 8 | Blue channel |

## Verification
The assertions check several relations on every cycle:
- colour is black whenever enable is low;
- enable never overlaps either sync;
- each horizontal pulse lasts exactly H_SYNC clocks;
- each request lies inside the image and is followed two cycles later by an enabled output;
- the low bits of each output channel always repeat its top bits.

Other behaviour can only be shown by the bench's sweep of whole frames against an arithmetic raster model:
- the exact position of each sync and enable edge;
- the rows where the black bands begin and end;
- the coordinates carried by each request;
- the exact colour values returned for each pixel.

// File: rtl/lbx_pkg.sv
package lbx_pkg;

    typedef struct packed {
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
    } rgb888_t;

    typedef struct packed {
        logic de;
        logic hs_n;
        logic vs_n;
        logic img;
    } raster_ctl_t;

    localparam raster_ctl_t CTL_IDLE = '{de: 1'b0, hs_n: 1'b1, vs_n: 1'b1, img: 1'b0};

    function automatic rgb888_t widen565(input logic [15:0] w);
        rgb888_t c;
        c.r = {w[15:11], w[15:13]};
        c.g = {w[10:5], w[10:9]};
        c.b = {w[4:0], w[4:2]};
        return c;
    endfunction

endpackage

// File: rtl/lbx_axis_counter.sv
module lbx_axis_counter #(
    parameter int ACTIVE = 1024,
    parameter int FP     = 24,
    parameter int SYNC   = 136,
    parameter int BP     = 160,
    localparam int TOTAL = ACTIVE + FP + SYNC + BP,
    localparam int CW    = $clog2(TOTAL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [CW-1:0] pos,
    output logic          wrap,
    output logic          in_active,
    output logic          in_sync
);

    localparam logic [CW-1:0] LAST       = CW'(TOTAL - 1);
    localparam logic [CW-1:0] SYNC_START = CW'(ACTIVE + FP);
    localparam logic [CW-1:0] SYNC_END   = CW'(ACTIVE + FP + SYNC);
    localparam logic [CW-1:0] ACT_END    = CW'(ACTIVE);

    typedef struct packed {
        logic [CW-1:0] pos;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step) begin
            if (st_q.pos == LAST) begin
                st_d.pos = '0;
            end else begin
                st_d.pos = st_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pos       = st_q.pos;
    assign wrap      = step && (st_q.pos == LAST);
    assign in_active = st_q.pos < ACT_END;
    assign in_sync   = (st_q.pos >= SYNC_START) && (st_q.pos < SYNC_END);

endmodule

// File: rtl/lbx_pixel_stage.sv
module lbx_pixel_stage
    import lbx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  raster_ctl_t ctl_i,
    input  logic [15:0] pix_i,
    output raster_ctl_t ctl_o,
    output rgb888_t     rgb_o
);

    typedef struct packed {
        raster_ctl_t mid;
        raster_ctl_t out;
        rgb888_t     rgb;
    } pstage_t;

    pstage_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.mid = ctl_i;
        st_d.out = st_q.mid;
        if (st_q.mid.img) begin
            st_d.rgb = widen565(pix_i);
        end else begin
            st_d.rgb = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mid <= CTL_IDLE;
            st_q.out <= CTL_IDLE;
            st_q.rgb <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_o = st_q.out;
    assign rgb_o = st_q.rgb;

endmodule

// File: rtl/letterbox_xga_timing.sv
module letterbox_xga_timing
    import lbx_pkg::*;
#(
    parameter int H_ACTIVE  = 1024,
    parameter int H_FP      = 24,
    parameter int H_SYNC    = 136,
    parameter int H_BP      = 160,
    parameter int V_ACTIVE  = 768,
    parameter int V_FP      = 3,
    parameter int V_SYNC    = 6,
    parameter int V_BP      = 29,
    parameter int IMG_TOP   = 24,
    parameter int IMG_LINES = 720,
    localparam int COLW     = $clog2(H_ACTIVE),
    localparam int ROWW     = $clog2(IMG_LINES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [15:0]     pix_rgb565,
    output logic            pix_req,
    output logic [COLW-1:0] req_col,
    output logic [ROWW-1:0] req_row,
    output logic            hsync_n,
    output logic            vsync_n,
    output logic            disp_de,
    output logic [7:0]      red,
    output logic [7:0]      green,
    output logic [7:0]      blue
);

    localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP;
    localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP;
    localparam int HW      = $clog2(H_TOTAL);
    localparam int VW      = $clog2(V_TOTAL);
    localparam logic [VW-1:0] BAND_LO = VW'(IMG_TOP);
    localparam logic [VW-1:0] BAND_HI = VW'(IMG_TOP + IMG_LINES);

    logic [HW-1:0] h_pos;
    logic [VW-1:0] v_pos;
    logic          h_wrap, h_act, h_syn;
    logic          v_wrap, v_act, v_syn;

    lbx_axis_counter #(
        .ACTIVE(H_ACTIVE), .FP(H_FP), .SYNC(H_SYNC), .BP(H_BP)
    ) u_hcnt (
        .clk(clk), .rst_n(rst_n), .step(1'b1),
        .pos(h_pos), .wrap(h_wrap), .in_active(h_act), .in_sync(h_syn)
    );

    lbx_axis_counter #(
        .ACTIVE(V_ACTIVE), .FP(V_FP), .SYNC(V_SYNC), .BP(V_BP)
    ) u_vcnt (
        .clk(clk), .rst_n(rst_n), .step(h_wrap),
        .pos(v_pos), .wrap(v_wrap), .in_active(v_act), .in_sync(v_syn)
    );

    typedef struct packed {
        raster_ctl_t     ctl;
        logic [COLW-1:0] col;
        logic [ROWW-1:0] row;
    } decode_t;

    decode_t dec_d, dec_q;
    logic    in_band;
    logic    unused_vwrap;

    assign unused_vwrap = v_wrap;
    assign in_band      = (v_pos >= BAND_LO) && (v_pos < BAND_HI);

    always_comb begin
        dec_d          = dec_q;
        dec_d.ctl.de   = h_act && v_act;
        dec_d.ctl.hs_n = !h_syn;
        dec_d.ctl.vs_n = !v_syn;
        dec_d.ctl.img  = h_act && v_act && in_band;
        dec_d.col      = COLW'(h_pos);
        dec_d.row      = ROWW'(v_pos - BAND_LO);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q.ctl <= CTL_IDLE;
            dec_q.col <= '0;
            dec_q.row <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    raster_ctl_t out_ctl;
    rgb888_t     out_rgb;

    lbx_pixel_stage u_pix (
        .clk(clk), .rst_n(rst_n),
        .ctl_i(dec_q.ctl), .pix_i(pix_rgb565),
        .ctl_o(out_ctl), .rgb_o(out_rgb)
    );

    assign pix_req = dec_q.ctl.img;
    assign req_col = dec_q.col;
    assign req_row = dec_q.row;
    assign hsync_n = out_ctl.hs_n;
    assign vsync_n = out_ctl.vs_n;
    assign disp_de = out_ctl.de;
    assign red     = out_rgb.r;
    assign green   = out_rgb.g;
    assign blue    = out_rgb.b;

endmodule

// File: rtl/lbx_timing_checker.sv
module lbx_timing_checker #(
    parameter int H_ACTIVE  = 1024,
    parameter int H_SYNC    = 136,
    parameter int IMG_LINES = 720,
    localparam int COLW     = $clog2(H_ACTIVE),
    localparam int ROWW     = $clog2(IMG_LINES)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            pix_req,
    input logic [COLW-1:0] req_col,
    input logic [ROWW-1:0] req_row,
    input logic            hsync_n,
    input logic            vsync_n,
    input logic            disp_de,
    input logic [7:0]      red,
    input logic [7:0]      green,
    input logic [7:0]      blue
);

    logic [15:0] hs_low_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_low_cnt <= '0;
        end else if (!hsync_n) begin
            hs_low_cnt <= hs_low_cnt + 16'd1;
        end else begin
            hs_low_cnt <= '0;
        end
    end

    assert_hsync_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hsync_n) |-> hs_low_cnt == 16'(H_SYNC));

    assert_vsync_blank_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync_n |-> !disp_de);

    assert_hsync_blank_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !hsync_n |-> !disp_de);

    assert_req_inside_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pix_req |-> (32'(req_col) < H_ACTIVE) && (32'(req_row) < IMG_LINES));

    assert_black_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_de |-> (red == 8'd0) && (green == 8'd0) && (blue == 8'd0));

    assert_replicate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (red[2:0] == red[7:5]) && (green[1:0] == green[7:6]) && (blue[2:0] == blue[7:5]));

    assert_req_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pix_req |-> ##2 disp_de);

endmodule

bind letterbox_xga_timing lbx_timing_checker #(
    .H_ACTIVE(H_ACTIVE), .H_SYNC(H_SYNC), .IMG_LINES(IMG_LINES)
) i_lbx_chk (
    .clk(clk), .rst_n(rst_n), .pix_req(pix_req), .req_col(req_col),
    .req_row(req_row), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .disp_de(disp_de), .red(red), .green(green), .blue(blue)
);

// File: tb/test_letterbox_xga_timing.sv
module test_letterbox_xga_timing;

    localparam int HA = 8, HFP = 2, HS = 3, HBP = 2;
    localparam int VA = 6, VFP = 1, VS = 2, VBP = 1;
    localparam int IT = 1, IL = 4;
    localparam int HT = HA + HFP + HS + HBP;
    localparam int VT = VA + VFP + VS + VBP;
    localparam int FT = HT * VT;
    localparam int COLW = $clog2(HA);
    localparam int ROWW = $clog2(IL);

    logic            clk = 1'b0;
    logic            rst_n;
    logic [15:0]     pix_rgb565;
    logic            pix_req;
    logic [COLW-1:0] req_col;
    logic [ROWW-1:0] req_row;
    logic            hsync_n, vsync_n, disp_de;
    logic [7:0]      red, green, blue;

    always #2 clk = ~clk;

    letterbox_xga_timing #(
        .H_ACTIVE(HA), .H_FP(HFP), .H_SYNC(HS), .H_BP(HBP),
        .V_ACTIVE(VA), .V_FP(VFP), .V_SYNC(VS), .V_BP(VBP),
        .IMG_TOP(IT), .IMG_LINES(IL)
    ) i_letterbox_xga_timing (
        .clk(clk), .rst_n(rst_n), .pix_rgb565(pix_rgb565),
        .pix_req(pix_req), .req_col(req_col), .req_row(req_row),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .disp_de(disp_de),
        .red(red), .green(green), .blue(blue)
    );

    int  errors = 0;
    int  checks = 0;
    bit  done   = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int src_word(input int col, input int row);
        return (col * 9973 + row * 4111 + 16'h3A5C) & 16'hFFFF;
    endfunction

    function automatic int wide(input int v, input int bits);
        return (v << (8 - bits)) | (v >> (2 * bits - 8));
    endfunction

    task automatic check_pos(input int p);
        int h, v, w, er, eg, eb;
        bit de, img;
        h   = p % HT;
        v   = (p / HT) % VT;
        de  = (h < HA) && (v < VA);
        img = de && (v >= IT) && (v < IT + IL);
        chk(hsync_n == !((h >= HA + HFP) && (h < HA + HFP + HS)), "R1 hsync", int'(hsync_n), h);
        chk(vsync_n == !((v >= VA + VFP) && (v < VA + VFP + VS)), "R2 vsync", int'(vsync_n), v);
        chk(disp_de == de, "R3 de", int'(disp_de), int'(de));
        if (img) begin
            w  = src_word(h, v - IT);
            er = wide((w >> 11) & 31, 5);
            eg = wide((w >> 5) & 63, 6);
            eb = wide(w & 31, 5);
            chk(red == 8'(er), "R7 red", int'(red), er);
            chk(green == 8'(eg), "R7 green", int'(green), eg);
            chk(blue == 8'(eb), "R8 blue", int'(blue), eb);
        end else if (de) begin
            chk({red, green, blue} == 24'd0, "R5 band black", int'({red, green, blue}), 0);
        end else begin
            chk({red, green, blue} == 24'd0, "R6 blank black", int'({red, green, blue}), 0);
        end
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit pend_v;
        int pend_w;
        rst_n      = 1'b0;
        pix_rgb565 = 16'hFFFF;
        pend_v     = 1'b0;
        pend_w     = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(hsync_n && vsync_n, "R9 reset syncs", int'({hsync_n, vsync_n}), 3);
        chk(!disp_de && !pix_req, "R9 reset de/req", int'({disp_de, pix_req}), 0);
        chk({red, green, blue} == 24'd0, "R9 reset colour", int'({red, green, blue}), 0);
        rst_n = 1'b1;
        for (int k = 1; k <= 2 * FT + 6; k++) begin
            int p, h, v;
            bit er;
            @(posedge clk);
            @(negedge clk);
            pix_rgb565 = pend_v ? 16'(pend_w) : 16'hFFFF;
            p  = k - 1;
            h  = p % HT;
            v  = (p / HT) % VT;
            er = (h < HA) && (v >= IT) && (v < IT + IL) && (v < VA);
            chk(pix_req == er, "R4 req", int'(pix_req), int'(er));
            if (er) begin
                chk(int'(req_col) == h, "R4 col", int'(req_col), h);
                chk(int'(req_row) == v - IT, "R4 row", int'(req_row), v - IT);
            end
            pend_v = er;
            pend_w = er ? src_word(h, v - IT) : 0;
            if (k >= 3) begin
                check_pos(k - 3);
            end else begin
                chk(hsync_n && vsync_n && !disp_de, "R9 start idle", int'({hsync_n, vsync_n, disp_de}), 6);
            end
        end
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule